// File: doc/BRIEF.md
# Cached Line Access-Rights Filter

This block sits on one node's processor bus in a cache-coherent NUMA machine. It keeps a small direct-mapped cache of access rights for recently used 64-byte lines, whether the line's memory is on this node or the line is a remote one held in the node's L3 cache. For every bus request it answers, one cycle later, whether the request may proceed, must wait, or hits a line that is locked out by a coherence fault. When the request must wait, it raises a lookup toward the coherency engine.

The coherency engine fills, upgrades and downgrades entries through an update port. With each update it sends a summary of the authoritative directory state. The block compares that summary with the rights being installed. If the directory reports no remote copies while the rights say the line is modified elsewhere, the block sets a sticky panic flag and refuses all further grants for that line. A small home-node table, indexed by the top address bits, can be written only while a configuration enable is high. Each response also carries the home node of the requested line.

Top module: `line_rights_filter`

## Requirements
- R1: After reset every line misses in the rights cache, so any bus request is answered with postpone (code 2'b10), and panic is low.
- R2: Rights codes are 2'b00 no access, 2'b01 read-only, 2'b11 full; 2'b10 is treated as no access. A bus read (bus_write=0) that hits an entry holding read-only or full is answered with allow (code 2'b01).
- R3: A bus write (bus_write=1) is answered with allow only when the entry hits with full rights. A hit with read-only is answered with postpone.
- R4: Whenever the response is postpone, lkup_valid is high in the same cycle and lkup_line equals the request address shifted right by 6.
- R5: A request accepted on a clock edge gets exactly one response (rsp_valid high) in the following cycle. With no request, rsp_valid and lkup_valid are low.
- R6: When an update and a bus request name the same line in the same cycle, the response reflects the rights installed by that update.
- R7: The cache is direct-mapped on line bits [7:0]. Installing a line with the same index but a different tag evicts the older line, and a request to the older line then misses.
- R8: A downgrade to no access is honoured immediately. A read of a line that was read-only is postponed after it is downgraded.
- R9: An update with directory summary 2'b00 (no remote copies) and new rights 2'b00 raises panic one cycle later. Panic then stays high until reset, and later updates do not clear it. Summary 2'b01 means remote shared and 2'b10 remote modified.
- R10: A request to the line that caused the panic, including one in the same cycle as the faulting update, is answered with error (code 2'b11). Requests to other lines are still decided by their rights.
- R11: Each response carries, in rsp_home, the home node stored for region bus_addr[31:28]. The table is zero after reset, and writes to it are ignored while cfg_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Opens the home-node table for writing |
| cfg_we | input | 1 | Home-node table write strobe |
| cfg_region | input | 4 | Region index to write |
| cfg_node | input | 3 | Home node for that region |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_addr | input | 32 | Request byte address |
| bus_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 01 allow, 10 postpone, 11 error, 00 idle |
| rsp_home | output | 3 | Home node of the requested line |
| lkup_valid | output | 1 | Lookup request to the coherency engine |
| lkup_line | output | 26 | Line number to look up |
| upd_valid | input | 1 | Rights update present |
| upd_addr | input | 32 | Byte address of the updated line |
| upd_rights | input | 2 | New rights code |
| upd_dir | input | 2 | Directory summary: 00 none, 01 shared, 10 modified |
| panic | output | 1 | Sticky coherence-fault flag |
| panic_line | output | 26 | Line that raised the fault |

## Verification
The response code, rsp_home, lkup_valid and lkup_line all come from requests accepted on a rising edge and are due in the next cycle. Panic appears one cycle after the faulting update. An update becomes visible to lookups in the same cycle it is presented. The bench drives every input on the falling edge and reads the results on the next falling edge, halfway through the cycle in which they are due. Each scenario then drops its strobes, so no response can be mistaken for the result of a later request.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_RO   = 2'b01,
    RT_RSV  = 2'b10,
    RT_FULL = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    RC_IDLE  = 2'b00,
    RC_ALLOW = 2'b01,
    RC_WAIT  = 2'b10,
    RC_ERR   = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    DIR_LOCAL  = 2'b00,
    DIR_SHARED = 2'b01,
    DIR_MOD    = 2'b10,
    DIR_RSV    = 2'b11
  } dir_e;

  // Decide a bus request from cached rights; a locked line wins over everything.
  function automatic rsp_e judge(input logic hit, input logic [1:0] rights,
                                 input logic is_write, input logic blocked);
    logic enough;
    if (is_write) enough = (rights == RT_FULL);
    else          enough = (rights == RT_FULL) || (rights == RT_RO);
    if (blocked)              return RC_ERR;
    else if (hit && enough)   return RC_ALLOW;
    else                      return RC_WAIT;
  endfunction

  // Directory holds no remote copy, yet the rights claim a remote modified copy.
  function automatic logic dir_conflict(input logic [1:0] dir, input logic [1:0] rights);
    return (dir == DIR_LOCAL) && (rights == RT_NONE);
  endfunction

endpackage

// File: rtl/lrf_home_map.sv
module lrf_home_map #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int NODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [NODE_W-1:0] rd_node
);

  logic [ENTRIES-1:0][NODE_W-1:0] map_q;
  logic                           map_wr;

  assign map_wr = cfg_en && cfg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) map_q <= '0;
    else if (map_wr) map_q[cfg_idx] <= cfg_node;
  end

  assign rd_node = map_q[rd_idx];

  // R11: table contents frozen whenever configuration is closed
  a_r11_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(map_q));

endmodule

// File: rtl/lrf_rights_store.sv
module lrf_rights_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_we,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [1:0]       upd_rights,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [1:0]       rd_rights,
  output logic             bypass_used
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [1:0]       rts_mem [DEPTH];

  logic             eff_valid;
  logic [TAG_W-1:0] eff_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (upd_we) valid_q[upd_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_we) begin
      tag_mem[upd_idx] <= upd_tag;
      rts_mem[upd_idx] <= upd_rights;
    end
  end

  // Same-index update is forwarded so the lookup sees the post-update entry.
  assign bypass_used = upd_we && (upd_idx == rd_idx);
  assign eff_valid   = bypass_used || valid_q[rd_idx];
  assign eff_tag     = bypass_used ? upd_tag    : tag_mem[rd_idx];
  assign rd_rights   = bypass_used ? upd_rights : rts_mem[rd_idx];
  assign rd_hit      = eff_valid && (eff_tag == rd_tag);

  // R7: an entry only becomes valid through an update
  a_r7_valid_by_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_we |=> $stable(valid_q));

endmodule

// File: rtl/line_rights_filter.sv
module line_rights_filter
  import lrf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_IDX_W = 8,
  parameter int NODE_W      = 3,
  parameter int MAP_IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [MAP_IDX_W-1:0] cfg_region,
  input  logic [NODE_W-1:0]    cfg_node,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_write,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [NODE_W-1:0]    rsp_home,
  output logic                 lkup_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] lkup_line,
  input  logic                 upd_valid,
  input  logic [ADDR_W-1:0]    upd_addr,
  input  logic [1:0]           upd_rights,
  input  logic [1:0]           upd_dir,
  output logic                 panic,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] panic_line
);

  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int LINE_W      = ADDR_W - OFF_W;
  localparam int TAG_W       = LINE_W - CACHE_IDX_W;
  localparam int MAP_ENTRIES = 1 << MAP_IDX_W;

  logic [LINE_W-1:0] bus_line, upd_line;
  logic              st_hit;
  logic [1:0]        st_rights;
  logic              st_bypass;
  logic [NODE_W-1:0] home_now;
  logic              upd_conflict;
  logic              blocked_now;
  rsp_e              code_now;

  logic              rsp_valid_q, lkup_valid_q, panic_q;
  rsp_e              rsp_code_q;
  logic [NODE_W-1:0] rsp_home_q;
  logic [LINE_W-1:0] lkup_line_q, panic_line_q;

  assign bus_line = bus_addr[ADDR_W-1:OFF_W];
  assign upd_line = upd_addr[ADDR_W-1:OFF_W];

  lrf_rights_store #(.IDX_W(CACHE_IDX_W), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_we     (upd_valid),
    .upd_idx    (upd_line[CACHE_IDX_W-1:0]),
    .upd_tag    (upd_line[LINE_W-1:CACHE_IDX_W]),
    .upd_rights (upd_rights),
    .rd_idx     (bus_line[CACHE_IDX_W-1:0]),
    .rd_tag     (bus_line[LINE_W-1:CACHE_IDX_W]),
    .rd_hit     (st_hit),
    .rd_rights  (st_rights),
    .bypass_used(st_bypass)
  );

  lrf_home_map #(.ENTRIES(MAP_ENTRIES), .IDX_W(MAP_IDX_W), .NODE_W(NODE_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_we  (cfg_we),
    .cfg_idx (cfg_region),
    .cfg_node(cfg_node),
    .rd_idx  (bus_addr[ADDR_W-1 -: MAP_IDX_W]),
    .rd_node (home_now)
  );

  // Fault detection; a fault raised this cycle already locks its own line.
  assign upd_conflict = upd_valid && dir_conflict(upd_dir, upd_rights);
  assign blocked_now  = (panic_q && (bus_line == panic_line_q)) ||
                        (!panic_q && upd_conflict && (bus_line == upd_line));
  assign code_now     = judge(st_hit, st_rights, bus_write, blocked_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_code_q   <= RC_IDLE;
      rsp_home_q   <= '0;
      lkup_valid_q <= 1'b0;
      lkup_line_q  <= '0;
    end else begin
      rsp_valid_q  <= bus_valid;
      rsp_code_q   <= bus_valid ? code_now : RC_IDLE;
      rsp_home_q   <= home_now;
      lkup_valid_q <= bus_valid && (code_now == RC_WAIT);
      lkup_line_q  <= bus_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      panic_q      <= 1'b0;
      panic_line_q <= '0;
    end else if (!panic_q && upd_conflict) begin
      panic_q      <= 1'b1;
      panic_line_q <= upd_line;
    end
  end

  assign bus_ready  = 1'b1;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_code   = rsp_code_q;
  assign rsp_home   = rsp_home_q;
  assign lkup_valid = lkup_valid_q;
  assign lkup_line  = lkup_line_q;
  assign panic      = panic_q;
  assign panic_line = panic_line_q;

  // R5: one response per request, one cycle later
  a_r5_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);
  a_r5_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid && !lkup_valid);
  // R4: a lookup only accompanies a postpone
  a_r4_lkup_with_wait: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_valid |-> rsp_valid && rsp_code == RC_WAIT);
  // R3: no write is allowed without full rights from the store
  a_r3_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && !(st_hit && st_rights == RT_FULL) |=> rsp_code != RC_ALLOW);
  // R9: panic is sticky and keeps its line
  a_r9_panic_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    panic_q |=> panic_q && $stable(panic_line_q));
  a_r9_panic_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panic_q) |-> $past(upd_valid) && $past(upd_dir) == 2'b00 && $past(upd_rights) == 2'b00);
  // R10: the faulted line is refused
  a_r10_locked_err: assert property (@(posedge clk) disable iff (!rst_n)
    panic_q && bus_valid && bus_line == panic_line_q |=> rsp_code == RC_ERR);

endmodule

// File: tb/tb_line_rights_filter.sv
module tb_line_rights_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_region = '0;
  logic [2:0]  cfg_node = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_ready;
  logic        rsp_valid, lkup_valid, panic;
  logic [1:0]  rsp_code;
  logic [2:0]  rsp_home;
  logic [25:0] lkup_line, panic_line;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_addr = '0;
  logic [1:0]  upd_rights = '0, upd_dir = '0;

  int total = 0;
  int bad = 0;

  localparam logic [1:0] ALLOW = 2'b01, WAIT = 2'b10, ERR = 2'b11;

  always #4 clk = ~clk;

  line_rights_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_region(cfg_region), .cfg_node(cfg_node),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_write(bus_write),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_home(rsp_home),
    .lkup_valid(lkup_valid), .lkup_line(lkup_line),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_rights(upd_rights), .upd_dir(upd_dir),
    .panic(panic), .panic_line(panic_line)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one request on a falling edge, read its response one falling edge later.
  task automatic bus_req(input logic [31:0] a, input logic wr);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = wr;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic upd(input logic [31:0] a, input logic [1:0] r, input logic [1:0] d);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_rights = r; upd_dir = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic both(input logic [31:0] ua, input logic [1:0] r, input logic [1:0] d,
                      input logic [31:0] ba, input logic wr);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = ua; upd_rights = r; upd_dir = d;
    bus_valid = 1'b1; bus_addr = ba; bus_write = wr;
    @(negedge clk);
    upd_valid = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 panic after reset", panic, 0);
    chk("R5 no response idle", rsp_valid, 0);
    bus_req(32'h0000_1000, 1'b0);
    chk("R1 miss after reset", rsp_code, WAIT);
    chk("R4 lookup raised", lkup_valid, 1);
    chk("R4 lookup line", lkup_line, 32'h40);
    chk("R5 response present", rsp_valid, 1);
    @(negedge clk);
    chk("R5 response gone", rsp_valid, 0);
    chk("R5 lookup gone", lkup_valid, 0);
  endtask

  task automatic t_rights;
    upd(32'h0000_1000, 2'b01, 2'b01);
    bus_req(32'h0000_1004, 1'b0);
    chk("R2 read with read-only", rsp_code, ALLOW);
    chk("R4 no lookup on allow", lkup_valid, 0);
    bus_req(32'h0000_1000, 1'b1);
    chk("R3 write with read-only", rsp_code, WAIT);
    upd(32'h0000_1000, 2'b11, 2'b00);
    bus_req(32'h0000_103C, 1'b1);
    chk("R3 write with full", rsp_code, ALLOW);
    bus_req(32'h0000_1000, 1'b0);
    chk("R2 read with full", rsp_code, ALLOW);
    upd(32'h0000_1000, 2'b10, 2'b01);
    bus_req(32'h0000_1000, 1'b0);
    chk("R2 reserved code denies", rsp_code, WAIT);
  endtask

  task automatic t_downgrade;
    upd(32'h0000_2000, 2'b01, 2'b10);
    bus_req(32'h0000_2000, 1'b0);
    chk("R8 read copy allowed", rsp_code, ALLOW);
    upd(32'h0000_2000, 2'b00, 2'b01);
    bus_req(32'h0000_2000, 1'b0);
    chk("R8 read after downgrade", rsp_code, WAIT);
    chk("R8 lookup line", lkup_line, 32'h80);
  endtask

  task automatic t_evict;
    upd(32'h0000_1000, 2'b11, 2'b00);
    upd(32'h0000_5000, 2'b11, 2'b00);
    bus_req(32'h0000_1000, 1'b0);
    chk("R7 older line evicted", rsp_code, WAIT);
    bus_req(32'h0000_5000, 1'b1);
    chk("R7 newer line hits", rsp_code, ALLOW);
  endtask

  task automatic t_same_cycle;
    upd(32'h0000_3000, 2'b11, 2'b00);
    both(32'h0000_3000, 2'b00, 2'b10, 32'h0000_3000, 1'b0);
    chk("R6 downgrade seen same cycle", rsp_code, WAIT);
    both(32'h0000_3040, 2'b01, 2'b01, 32'h0000_3040, 1'b0);
    chk("R6 fill seen same cycle", rsp_code, ALLOW);
  endtask

  task automatic t_home;
    bus_req(32'h3000_0000, 1'b0);
    chk("R11 table zero after reset", rsp_home, 0);
    @(negedge clk);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_region = 4'h3; cfg_node = 3'd5;
    @(negedge clk);
    cfg_en = 1'b0; cfg_region = 4'h3; cfg_node = 3'd2;
    @(negedge clk);
    cfg_we = 1'b0;
    bus_req(32'h3000_0040, 1'b0);
    chk("R11 home node, closed write ignored", rsp_home, 5);
    bus_req(32'h4000_0040, 1'b0);
    chk("R11 other region", rsp_home, 0);
  endtask

  task automatic t_panic;
    upd(32'h0000_6000, 2'b11, 2'b00);
    chk("R9 no panic before fault", panic, 0);
    both(32'h0000_8000, 2'b00, 2'b00, 32'h0000_8000, 1'b0);
    chk("R10 same-cycle faulted line", rsp_code, ERR);
    chk("R9 panic raised", panic, 1);
    chk("R9 panic line", panic_line, 32'h200);
    bus_req(32'h0000_8010, 1'b0);
    chk("R10 faulted line refused", rsp_code, ERR);
    chk("R10 no lookup on error", lkup_valid, 0);
    bus_req(32'h0000_6000, 1'b1);
    chk("R10 other line unaffected", rsp_code, ALLOW);
    upd(32'h0000_8000, 2'b11, 2'b00);
    chk("R9 panic sticky", panic, 1);
    bus_req(32'h0000_8000, 1'b0);
    chk("R10 still refused", rsp_code, ERR);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rights();
    t_downgrade();
    t_evict();
    t_same_cycle();
    t_home();
    t_panic();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule